// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block pairs two eight-line priority interrupt controllers in a cascade. The second-level (slave) controller serves request lines 15..8, and its output feeds line 2 of the first-level (master) controller, which serves lines 7..0. The block keeps the request, edge-history, in-service and rotation state of both levels. It drives one interrupt line to the processor. When the processor acknowledges, it returns an 8-bit vector and updates both levels together on a single clock edge.

Each level takes a 5-bit vector base and two mode bits: automatic end-of-interrupt, and rotation on automatic end-of-interrupt. Software programs the two trigger-mode registers through a small write port. Each of these registers has a fixed set of writable bits. Command decoding and mask registers belong to a neighbouring block and are not part of this one.

Top module: `pic_cas_ack`

## Requirements
- R1: After a synchronous active-low reset, `cpu_int` and `vec_valid` are 0, both in-service registers read 0, and both trigger-mode registers read 0.
- R2: A trigger-mode write stores `trg_wdata & 8'hF8` when `trg_sel` is 0 (master) and `trg_wdata & 8'hDE` when `trg_sel` is 1 (slave). A trigger bit of 1 means level mode and 0 means edge mode.
- R3: An edge-mode line latches a request on a 0-to-1 change of its input and holds it until it is acknowledged. A level-mode line's request follows its input. `cpu_int` is high exactly while the master has a winning line, which is one clock after the master input rises.
- R4: Within a level, priority runs upward from the rotation base (0 after reset), wrapping modulo 8. A request wins only if its priority is strictly higher than that of every in-service line.
- R5: The clock edge that samples `ack` high loads `vector = {base, line}`, and `vec_valid` is high for exactly the one following cycle.
- R6: Without auto-EOI, an acknowledge sets the winning line's in-service bit. It clears that line's request only when the line is in edge mode; a level-mode request stays pending.
- R7: With auto-EOI, the in-service register is unchanged by the acknowledge. If rotation is also enabled, the rotation base becomes the acknowledged line + 1.
- R8: A slave winner sets master request 2 (always edge mode) one clock later. The physical input on master line 2 (`req_lines[2]`) has no effect.
- R9: When the master winner is line 2, the slave's winner is acknowledged as in R6/R7. The vector is `{slv_base, slave line}` and master in-service bit 2 is set.
- R10: When the master winner is line 2 but the slave has no winner, the vector is `{slv_base, 3'd7}` and the slave state is unchanged.
- R11: An acknowledge while the master has no winner returns `{mst_base, 3'd7}` and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 16 | Request inputs; 7..0 master, 15..8 slave |
| ack | input | 1 | Processor acknowledge strobe |
| mst_base | input | 5 | Master vector base (upper five bits) |
| slv_base | input | 5 | Slave vector base (upper five bits) |
| mst_aeoi | input | 1 | Master auto-EOI enable |
| mst_rot_aeoi | input | 1 | Master rotate on auto-EOI |
| slv_aeoi | input | 1 | Slave auto-EOI enable |
| slv_rot_aeoi | input | 1 | Slave rotate on auto-EOI |
| trg_we | input | 1 | Trigger-mode register write strobe |
| trg_sel | input | 1 | 0 selects master, 1 selects slave |
| trg_wdata | input | 8 | Trigger-mode write data |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle per acknowledge |
| vector | output | 8 | Acknowledged vector |
| mst_isr | output | 8 | Master in-service register |
| slv_isr | output | 8 | Slave in-service register |
| mst_trg | output | 8 | Master trigger-mode register |
| slv_trg | output | 8 | Slave trigger-mode register |

## Verification
- A master request is visible on `cpu_int` one clock after its input is sampled.
- A slave request takes two clocks to reach `cpu_int`, because it passes through master line 2. The bench checks that `cpu_int` is still low after the first clock.
- The vector, `vec_valid` and the in-service registers change on the edge that samples `ack`. The bench reads them at the following falling edge, then checks one cycle later that `vec_valid` has dropped.
- All stimulus is applied at falling edges, so every check samples a settled value exactly the stated number of rising edges after its cause.

// File: rtl/pic_cas_pkg.sv
// Package: shared sizes, masks and types for the cascaded acknowledge unit.
// Assumes eight lines per level (a power of two) and an 8-bit vector.
package pic_cas_pkg;
    localparam int LINES        = 8;
    localparam int LW           = $clog2(LINES);
    localparam int VW           = 8;
    localparam int BW           = VW - LW;
    localparam int CASC_LINE    = 2;
    localparam logic [LINES-1:0] MST_TRG_MASK = 8'hF8;
    localparam logic [LINES-1:0] SLV_TRG_MASK = 8'hDE;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [LW-1:0]    line_idx_t;

    localparam line_idx_t SPUR_IDX = line_idx_t'(LINES - 1);
    localparam line_idx_t CASC_IDX = line_idx_t'(CASC_LINE);
endpackage

// File: rtl/pic_cas_resolver.sv
// Module: rotating priority resolver for one level.
// Finds the highest-priority pending line, counting upward from rot_base,
// and reports it only when it beats every in-service line.
// Assumes N is a power of two.
module pic_cas_resolver #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0]         isr,
    input  logic [$clog2(N)-1:0] rot_base,
    output logic                 win,
    output logic [$clog2(N)-1:0] win_line
);
    localparam int LWL = $clog2(N);
    localparam int PW  = LWL + 1;

    logic [N-1:0]  rot_req;
    logic [N-1:0]  rot_isr;
    logic [PW-1:0] pr_req;
    logic [PW-1:0] pr_isr;

    // Purpose: rotate both vectors so that priority 0 sits at bit 0, then find the first set bit.
    always_comb begin
        rot_req = '0;
        rot_isr = '0;
        for (int p = 0; p < N; p++) begin
            rot_req[p] = req[LWL'(LWL'(p) + rot_base)];
            rot_isr[p] = isr[LWL'(LWL'(p) + rot_base)];
        end
        pr_req = PW'(N);
        pr_isr = PW'(N);
        for (int p = N - 1; p >= 0; p--) begin
            if (rot_req[p]) pr_req = PW'(p);
            if (rot_isr[p]) pr_isr = PW'(p);
        end
    end

    // Purpose: a winner exists only with strictly better priority than the current service level.
    always_comb begin
        win      = (pr_req < pr_isr);
        win_line = pr_req[LWL-1:0] + rot_base;
    end
endmodule

// File: rtl/pic_cas_bank.sv
// Module: state of one controller level (requests, edge history,
// in-service, rotation base, trigger mode) plus its resolver.
// When CASC_EN is set, line CASC_LINE ignores its pin and is set by casc_set.
// Assumes ack_do is raised only while win is high.
module pic_cas_bank
    import pic_cas_pkg::*;
#(
    parameter int        N         = LINES,
    parameter logic [N-1:0] TRG_MASK = '1,
    parameter bit        CASC_EN   = 1'b0,
    parameter int        CLINE     = CASC_LINE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         line_in,
    input  logic                 casc_set,
    input  logic                 trg_we,
    input  logic [N-1:0]         trg_wdata,
    input  logic                 ack_do,
    input  logic                 aeoi,
    input  logic                 rot_aeoi,
    output logic                 win,
    output logic [$clog2(N)-1:0] win_line,
    output logic [N-1:0]         isr_q,
    output logic [N-1:0]         trg_q
);
    localparam int LWL = $clog2(N);
    localparam logic [N-1:0] CASC_MASK = CASC_EN ? (N'(1) << CLINE) : '0;

    logic [N-1:0]   irr_q, last_q;
    logic [LWL-1:0] rb_q;
    logic [N-1:0]   line_eff, irr_upd, irr_nxt, isr_nxt, trg_nxt, sel;
    logic [LWL-1:0] rb_nxt;

    pic_cas_resolver #(.N(N)) u_res (
        .req      (irr_q),
        .isr      (isr_q),
        .rot_base (rb_q),
        .win      (win),
        .win_line (win_line)
    );

    // Purpose: merge pin activity (edge or level per line) and the cascade pulse into the request set.
    always_comb begin
        line_eff = line_in & ~CASC_MASK;
        irr_upd  = (irr_q & ~trg_q)
                 | (line_eff & ~last_q & ~trg_q)
                 | (line_eff & trg_q)
                 | ({N{casc_set}} & CASC_MASK);
    end

    // Purpose: apply the acknowledge on top of the request update in the same edge.
    always_comb begin
        sel     = N'(1) << win_line;
        irr_nxt = irr_upd;
        isr_nxt = isr_q;
        rb_nxt  = rb_q;
        if (ack_do) begin
            irr_nxt = irr_upd & ~(sel & ~trg_q);
            if (!aeoi) begin
                isr_nxt = isr_q | sel;
            end else if (rot_aeoi) begin
                rb_nxt = win_line + LWL'(1);
            end
        end
        trg_nxt = trg_we ? (trg_wdata & TRG_MASK) : trg_q;
    end

    // Purpose: register the level's state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            last_q <= '0;
            isr_q  <= '0;
            rb_q   <= '0;
            trg_q  <= '0;
        end else begin
            irr_q  <= irr_nxt;
            last_q <= line_eff;
            isr_q  <= isr_nxt;
            rb_q   <= rb_nxt;
            trg_q  <= trg_nxt;
        end
    end
endmodule

// File: rtl/pic_cas_ack.sv
// Module: top of the cascaded acknowledge unit. Joins a master and a
// slave level (slave winner feeds master line 2), drives the processor
// interrupt, and forms the vector on acknowledge.
// Assumes ack is a single-cycle strobe; all state updates on that edge.
module pic_cas_ack
    import pic_cas_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*LINES-1:0] req_lines,
    input  logic            ack,
    input  logic [BW-1:0]   mst_base,
    input  logic [BW-1:0]   slv_base,
    input  logic            mst_aeoi,
    input  logic            mst_rot_aeoi,
    input  logic            slv_aeoi,
    input  logic            slv_rot_aeoi,
    input  logic            trg_we,
    input  logic            trg_sel,
    input  logic [LINES-1:0] trg_wdata,
    output logic            cpu_int,
    output logic            vec_valid,
    output logic [VW-1:0]   vector,
    output logic [LINES-1:0] mst_isr,
    output logic [LINES-1:0] slv_isr,
    output logic [LINES-1:0] mst_trg,
    output logic [LINES-1:0] slv_trg
);
    logic      m_win, s_win;
    line_idx_t m_line, s_line;
    logic      m_ack, s_ack;
    logic      m_is_casc;
    logic [VW-1:0] vec_d;
    logic [VW-1:0] vec_q;
    logic          vld_q;

    // Purpose: route acknowledge to each level; the slave only sees it through master line 2.
    always_comb begin
        m_is_casc = (m_line == CASC_IDX);
        m_ack     = ack & m_win;
        s_ack     = ack & m_win & m_is_casc & s_win;
    end

    pic_cas_bank #(
        .N(LINES), .TRG_MASK(MST_TRG_MASK), .CASC_EN(1'b1), .CLINE(CASC_LINE)
    ) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (req_lines[LINES-1:0]),
        .casc_set  (s_win),
        .trg_we    (trg_we & ~trg_sel),
        .trg_wdata (trg_wdata),
        .ack_do    (m_ack),
        .aeoi      (mst_aeoi),
        .rot_aeoi  (mst_rot_aeoi),
        .win       (m_win),
        .win_line  (m_line),
        .isr_q     (mst_isr),
        .trg_q     (mst_trg)
    );

    pic_cas_bank #(
        .N(LINES), .TRG_MASK(SLV_TRG_MASK), .CASC_EN(1'b0), .CLINE(CASC_LINE)
    ) u_slv (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (req_lines[2*LINES-1:LINES]),
        .casc_set  (1'b0),
        .trg_we    (trg_we & trg_sel),
        .trg_wdata (trg_wdata),
        .ack_do    (s_ack),
        .aeoi      (slv_aeoi),
        .rot_aeoi  (slv_rot_aeoi),
        .win       (s_win),
        .win_line  (s_line),
        .isr_q     (slv_isr),
        .trg_q     (slv_trg)
    );

    // Purpose: choose the vector, including both spurious cases.
    always_comb begin
        if (!m_win)
            vec_d = {mst_base, SPUR_IDX};
        else if (m_is_casc)
            vec_d = {slv_base, (s_win ? s_line : SPUR_IDX)};
        else
            vec_d = {mst_base, m_line};
    end

    // Purpose: register the vector and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= ack;
            if (ack) vec_q <= vec_d;
        end
    end

    assign cpu_int   = m_win;
    assign vec_valid = vld_q;
    assign vector    = vec_q;
endmodule

// File: rtl/pic_cas_ack_chk.sv
// Checker: temporal properties of the cascaded acknowledge unit, observed at its ports.
module pic_cas_ack_chk
    import pic_cas_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic [BW-1:0]    mst_base,
    input logic             mst_aeoi,
    input logic             trg_we,
    input logic             trg_sel,
    input logic [LINES-1:0] trg_wdata,
    input logic             cpu_int,
    input logic             vec_valid,
    input logic [VW-1:0]    vector,
    input logic [LINES-1:0] mst_isr,
    input logic [LINES-1:0] mst_trg,
    input logic [LINES-1:0] slv_trg
);
    a_r5_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);
    a_r2_master_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_we && !trg_sel) |=> (mst_trg == ($past(trg_wdata) & MST_TRG_MASK)));
    a_r2_slave_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_we && trg_sel) |=> (slv_trg == ($past(trg_wdata) & SLV_TRG_MASK)));
    a_r6_isr_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cpu_int && !mst_aeoi) |=> ($countones(mst_isr) == $countones($past(mst_isr)) + 1));
    a_r7_aeoi_isr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cpu_int && mst_aeoi) |=> (mst_isr == $past(mst_isr)));
    a_r11_spurious_master: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cpu_int) |=> ((vector == {$past(mst_base), SPUR_IDX}) && (mst_isr == $past(mst_isr))));
endmodule

bind pic_cas_ack pic_cas_ack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .mst_base  (mst_base),
    .mst_aeoi  (mst_aeoi),
    .trg_we    (trg_we),
    .trg_sel   (trg_sel),
    .trg_wdata (trg_wdata),
    .cpu_int   (cpu_int),
    .vec_valid (vec_valid),
    .vector    (vector),
    .mst_isr   (mst_isr),
    .mst_trg   (mst_trg),
    .slv_trg   (slv_trg)
);

// File: tb/pic_cas_ack_bench.sv
// Bench: directed scenarios for the cascaded acknowledge unit.
// Inputs are driven and outputs sampled at falling edges.
module pic_cas_ack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_lines = '0;
    logic        ack = 1'b0;
    logic [4:0]  mst_base = '0, slv_base = '0;
    logic        mst_aeoi = 1'b0, mst_rot_aeoi = 1'b0;
    logic        slv_aeoi = 1'b0, slv_rot_aeoi = 1'b0;
    logic        trg_we = 1'b0, trg_sel = 1'b0;
    logic [7:0]  trg_wdata = '0;
    logic        cpu_int, vec_valid;
    logic [7:0]  vector, mst_isr, slv_isr, mst_trg, slv_trg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pic_cas_ack u_pic_cas_ack (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .ack(ack),
        .mst_base(mst_base), .slv_base(slv_base),
        .mst_aeoi(mst_aeoi), .mst_rot_aeoi(mst_rot_aeoi),
        .slv_aeoi(slv_aeoi), .slv_rot_aeoi(slv_rot_aeoi),
        .trg_we(trg_we), .trg_sel(trg_sel), .trg_wdata(trg_wdata),
        .cpu_int(cpu_int), .vec_valid(vec_valid), .vector(vector),
        .mst_isr(mst_isr), .slv_isr(slv_isr), .mst_trg(mst_trg), .slv_trg(slv_trg)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_lines = '0; ack = 1'b0; trg_we = 1'b0;
        mst_aeoi = 0; mst_rot_aeoi = 0; slv_aeoi = 0; slv_rot_aeoi = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic write_trg(input logic sel, input logic [7:0] d);
        trg_we = 1'b1; trg_sel = sel; trg_wdata = d; step(1); trg_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cpu_int", 8'(cpu_int), 8'h0);
        chk("R1 vec_valid", 8'(vec_valid), 8'h0);
        chk("R1 mst_isr", mst_isr, 8'h00);
        chk("R1 slv_isr", slv_isr, 8'h00);
        chk("R1 trg", mst_trg | slv_trg, 8'h00);
    endtask

    task automatic t_trig_masks();
        do_reset();
        write_trg(1'b0, 8'hFF);
        chk("R2 master mask", mst_trg, 8'hF8);
        write_trg(1'b1, 8'hFF);
        chk("R2 slave mask", slv_trg, 8'hDE);
        chk("R2 master untouched", mst_trg, 8'hF8);
    endtask

    task automatic t_edge_master();
        do_reset();
        mst_base = 5'd4;
        req_lines[5] = 1'b1; step(1);
        chk("R3 cpu_int one clock after", 8'(cpu_int), 8'h1);
        pulse_ack();
        chk("R5 vec_valid", 8'(vec_valid), 8'h1);
        chk("R5 vector", vector, 8'h25);
        chk("R6 mst_isr set", mst_isr, 8'h20);
        chk("R4 isr blocks same line", 8'(cpu_int), 8'h0);
        step(1);
        chk("R5 valid single cycle", 8'(vec_valid), 8'h0);
    endtask

    task automatic t_priority();
        do_reset();
        mst_base = 5'd1;
        req_lines[3] = 1'b1; req_lines[6] = 1'b1; step(1);
        pulse_ack();
        chk("R4 lowest line wins", vector, 8'h0B);
        chk("R4 lower priority blocked", 8'(cpu_int), 8'h0);
        req_lines[1] = 1'b1; step(1);
        chk("R4 higher priority preempts", 8'(cpu_int), 8'h1);
        pulse_ack();
        chk("R4 nested vector", vector, 8'h09);
        chk("R6 nested isr", mst_isr, 8'h0A);
    endtask

    task automatic t_aeoi_rotate();
        do_reset();
        mst_base = 5'd2; mst_aeoi = 1'b1; mst_rot_aeoi = 1'b1;
        req_lines[3] = 1'b1; step(1);
        pulse_ack();
        chk("R7 vector line3", vector, 8'h13);
        chk("R7 isr stays clear", mst_isr, 8'h00);
        chk("R6 edge request cleared", 8'(cpu_int), 8'h0);
        req_lines[6] = 1'b1; req_lines[1] = 1'b1; step(1);
        pulse_ack();
        chk("R7 rotated winner line6", vector, 8'h16);
        pulse_ack();
        chk("R7 rotated then line1", vector, 8'h11);
    endtask

    task automatic t_level_mode();
        do_reset();
        write_trg(1'b0, 8'h20);
        mst_base = 5'd0; mst_aeoi = 1'b1;
        req_lines[5] = 1'b1; step(1);
        pulse_ack();
        chk("R6 level vector", vector, 8'h05);
        chk("R6 level request kept", 8'(cpu_int), 8'h1);
        req_lines[5] = 1'b0; step(1);
        chk("R3 level follows input", 8'(cpu_int), 8'h0);
    endtask

    task automatic t_cascade();
        do_reset();
        mst_base = 5'd1; slv_base = 5'h0E;
        req_lines[12] = 1'b1; step(1);
        chk("R8 one clock: not yet on master", 8'(cpu_int), 8'h0);
        step(1);
        chk("R8 two clocks: cpu_int", 8'(cpu_int), 8'h1);
        pulse_ack();
        chk("R9 slave vector", vector, 8'h74);
        chk("R9 master isr bit2", mst_isr, 8'h04);
        chk("R9 slave isr bit4", slv_isr, 8'h10);
    endtask

    task automatic t_casc_pin_ignored();
        do_reset();
        mst_base = 5'd3;
        req_lines[2] = 1'b1; step(3);
        chk("R8 master pin2 ignored", 8'(cpu_int), 8'h0);
    endtask

    task automatic t_slave_spurious();
        do_reset();
        slv_base = 5'h0E;
        write_trg(1'b1, 8'h10);
        req_lines[12] = 1'b1; step(2);
        chk("R10 cascade raised", 8'(cpu_int), 8'h1);
        req_lines[12] = 1'b0; step(1);
        chk("R10 master line2 held", 8'(cpu_int), 8'h1);
        pulse_ack();
        chk("R10 slave spurious vector", vector, 8'h77);
        chk("R10 master isr bit2", mst_isr, 8'h04);
        chk("R10 slave isr unchanged", slv_isr, 8'h00);
    endtask

    task automatic t_master_spurious();
        do_reset();
        mst_base = 5'h1F;
        pulse_ack();
        chk("R11 valid", 8'(vec_valid), 8'h1);
        chk("R11 vector", vector, 8'hFF);
        chk("R11 isr unchanged", mst_isr | slv_isr, 8'h00);
    endtask

    initial begin
        step(1);
        t_reset();
        t_trig_masks();
        t_edge_master();
        t_priority();
        t_aeoi_rotate();
        t_level_mode();
        t_cascade();
        t_casc_pin_ignored();
        t_slave_spurious();
        t_master_spurious();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule